// File: doc/BRIEF.md
# Linked-Descriptor Transmit Channel Sequencer

This block runs one transmit DMA channel whose work list is a chain of descriptors kept in memory. Software sets a current-descriptor pointer, sets the run bit, and then writes a tail pointer. The sequencer fetches the descriptor at the current pointer one word per read, word by word, and checks whether the descriptor has already been completed. It then passes the buffer address, byte length and frame-boundary flags to an external data mover. When the data mover reports done, the sequencer writes a completion status back into the descriptor, emits a one-cycle completion pulse and follows the descriptor's next pointer. It stops with the idle flag set once the descriptor equal to the tail pointer has been finished. It stops with the halted flag set if it fetches a descriptor that is already marked complete.

A descriptor occupies eight 32-bit little words starting at its address: word 0 is the next pointer, word 2 is the buffer address, word 6 is the control word and word 7 is the status word. Words 1, 3, 4 and 5 are fetched but not used. Only the low 32 bits of pointers are kept, and the application words that may follow a descriptor are not fetched. The memory read port returns data one cycle after the read strobe. The data mover holds nothing of its own in this block: it sees a request that stays high until it pulses done.

Registers are selected by word index (byte offset divided by four): control at index 0, status at 1, current pointer at 2, tail pointer at 4. Other indices read zero. The control register holds run (bit 0), the fixed tail-pointer-mode bit (bit 1) and soft reset (bit 2). The status register holds halted (bit 0) and idle (bit 1).

Top module: `sg_chain_ctrl`

## Requirements
- R1: After reset the control register reads 0x0001_0002, the status register reads 0x0000_0001 (halted), both pointers read 0, and no memory read or data-mover request is made.
- R2: Control bit 1 reads as 1 whatever value was written to it; the other written bits read back as written.
- R3: A control write with bit 0 set and bit 2 clear clears the halted and idle status bits, and on its own starts no descriptor fetch.
- R4: A tail write while bit 0 of control is set and the channel is at rest clears idle and starts a fetch of the eight words at current+0, +4, … +28, in that order. A tail write with the run bit clear only updates the tail register and causes no memory read.
- R5: The data-mover request carries word 2 as address, control bits 22:0 as length (bits 25:23 ignored), bit 27 as start of frame and bit 26 as end of frame, and it stays high with stable fields until done is pulsed.
- R6: After done, the status word at current+28 is written with the length ORed with 0x8000_0000, in the same cycle as a one-cycle completion pulse; one pulse is produced per finished descriptor.
- R7: After write-back the current pointer takes word 0 of the descriptor; the chain continues until the descriptor whose address equals the tail pointer has been finished, then the idle bit is set and fetching stops.
- R8: A fetched descriptor whose status bit 31 is already set sets the halted bit and stops the channel: no request, no write-back, no completion pulse, current pointer unchanged.
- R9: A control write with bit 2 set returns the channel to its reset state; the next control read returns 0x0001_0006 and clears bit 2, so a following read returns 0x0001_0002.
- R10: A tail write made while a descriptor is being fetched, transferred or written back is held pending and does not change the tail register; once the channel is at rest the held value is committed and, with the run bit set, processing restarts from the current pointer.
- R11: A tail write after the channel has gone idle or halted restarts processing from the current pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for the soft-reset self-clear) |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the index |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after the read strobe |
| xfer_req | output | 1 | Data-mover request, held until done |
| xfer_addr | output | 32 | Buffer address for the data mover |
| xfer_len | output | 23 | Byte length for the data mover |
| xfer_sof | output | 1 | Start-of-frame flag |
| xfer_eof | output | 1 | End-of-frame flag |
| xfer_done | input | 1 | One-cycle done pulse from the data mover |
| desc_done | output | 1 | One-cycle pulse per completed descriptor |

## Verification
Every cycle, the assertions check the handshake rules: the request stays up with steady fields until done, a completion pulse always coincides with a write whose data has the complete bit, the next cycle after a completion carries no request, read and write strobes never overlap, and the mode bit always reads as one. The bench's scenarios alone show the chain-level behaviour: the order of fetch addresses, the masking of the length field, the written-back status values, where the current pointer ends up, the idle stop at the tail, the halt on a pre-completed descriptor, the restart after a stop, the held tail write and the soft-reset read sequence.

// File: rtl/sg_pkg.sv
// Shared constants and types for the descriptor chain sequencer.
// Assumes 32-bit registers and memory words and byte addressing.
package sg_pkg;
    localparam int DW          = 32;            // register / memory word width
    localparam int LEN_W       = 23;            // descriptor length field width
    localparam int DESC_WORDS  = 8;             // words fetched per descriptor
    localparam int CNT_W       = $clog2(DESC_WORDS + 1);
    localparam int IDX_W       = $clog2(DESC_WORDS);
    localparam int RIDX_W      = 4;             // register word index width

    // register word indices
    localparam logic [RIDX_W-1:0] RI_CTRL = 4'd0;
    localparam logic [RIDX_W-1:0] RI_STAT = 4'd1;
    localparam logic [RIDX_W-1:0] RI_CUR  = 4'd2;
    localparam logic [RIDX_W-1:0] RI_TAIL = 4'd4;

    // control bits
    localparam int CB_RUN  = 0;
    localparam int CB_MODE = 1;
    localparam int CB_SRST = 2;
    localparam logic [DW-1:0] CTRL_INIT = 32'h0001_0002;

    // descriptor word positions and control-word bit positions
    localparam logic [IDX_W-1:0] DW_NEXT = 3'd0;
    localparam logic [IDX_W-1:0] DW_BUF  = 3'd2;
    localparam logic [IDX_W-1:0] DW_CTL  = 3'd6;
    localparam logic [IDX_W-1:0] DW_STS  = 3'd7;
    localparam int DB_EOF  = 26;
    localparam int DB_SOF  = 27;
    localparam int DB_CMPL = 31;
    localparam logic [DW-1:0] STS_OFFSET = 32'd28;

    typedef enum logic [2:0] {
        WK_REST, WK_FETCH, WK_CHECK, WK_XFER, WK_WB
    } walk_state_t;

    typedef struct packed {
        logic [DW-1:0]    nxt;
        logic [DW-1:0]    bufa;
        logic [LEN_W-1:0] len;
        logic             sof;
        logic             eof;
        logic             cmpl;
    } desc_t;
endpackage

// File: rtl/sg_desc_capture.sv
// Descriptor capture: stores the fields of interest as the fetched words
// arrive. Assumes cap_idx names the descriptor word present on cap_data.
module sg_desc_capture
    import sg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [IDX_W-1:0] cap_idx,
    input  logic [DW-1:0]    cap_data,
    output desc_t            desc
);
    // Latch each field when its word index comes by.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc <= '0;
        end else if (cap_en) begin
            case (cap_idx)
                DW_NEXT: desc.nxt  <= cap_data;
                DW_BUF:  desc.bufa <= cap_data;
                DW_CTL: begin
                    desc.len <= cap_data[LEN_W-1:0];
                    desc.sof <= cap_data[DB_SOF];
                    desc.eof <= cap_data[DB_EOF];
                end
                DW_STS:  desc.cmpl <= cap_data[DB_CMPL];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sg_walker.sv
// Chain walker: fetches a descriptor, checks it, hands it to the data
// mover, writes the status back and advances. Assumes memory read data
// arrives one cycle after mem_rd_en and that start only pulses at rest.
module sg_walker
    import sg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic [DW-1:0]    cur_ptr,
    input  logic [DW-1:0]    tail_ptr,
    output logic             mem_rd_en,
    output logic             mem_wr_en,
    output logic [DW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    output logic             xfer_req,
    output logic [DW-1:0]    xfer_addr,
    output logic [LEN_W-1:0] xfer_len,
    output logic             xfer_sof,
    output logic             xfer_eof,
    input  logic             xfer_done,
    output logic             desc_done,
    output logic             wk_halt,
    output logic             wk_idle,
    output logic             wk_adv,
    output logic [DW-1:0]    wk_next,
    output logic             busy
);
    walk_state_t      state;
    logic [CNT_W-1:0] cnt;
    desc_t            desc;
    logic             cap_en;
    logic [IDX_W-1:0] cap_idx;
    logic             at_tail;

    sg_desc_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .cap_idx  (cap_idx),
        .cap_data (mem_rdata),
        .desc     (desc)
    );

    // Sequence through fetch, check, transfer and write-back.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            state <= WK_REST;
            cnt   <= '0;
        end else begin
            case (state)
                WK_REST: if (start) begin
                    state <= WK_FETCH;
                    cnt   <= '0;
                end
                WK_FETCH: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_W'(DESC_WORDS)) state <= WK_CHECK;
                end
                WK_CHECK: state <= desc.cmpl ? WK_REST : WK_XFER;
                WK_XFER:  if (xfer_done) state <= WK_WB;
                WK_WB: begin
                    state <= at_tail ? WK_REST : WK_FETCH;
                    cnt   <= '0;
                end
                default: state <= WK_REST;
            endcase
        end
    end

    // Decode strobes, addresses and register-side events from the state.
    always_comb begin
        at_tail   = (cur_ptr == tail_ptr);
        mem_rd_en = (state == WK_FETCH) && (cnt < CNT_W'(DESC_WORDS));
        cap_en    = (state == WK_FETCH) && (cnt != '0);
        cap_idx   = IDX_W'(cnt - 1'b1);
        mem_addr  = (state == WK_FETCH) ? cur_ptr + (DW'(cnt) << 2)
                                        : cur_ptr + STS_OFFSET;
        mem_wr_en = (state == WK_WB);
        mem_wdata = {1'b1, {(DW-1-LEN_W){1'b0}}, desc.len};
        xfer_req  = (state == WK_XFER);
        xfer_addr = desc.bufa;
        xfer_len  = desc.len;
        xfer_sof  = desc.sof;
        xfer_eof  = desc.eof;
        desc_done = (state == WK_WB);
        wk_adv    = (state == WK_WB);
        wk_next   = desc.nxt;
        wk_idle   = (state == WK_WB) && at_tail;
        wk_halt   = (state == WK_CHECK) && desc.cmpl;
        busy      = (state != WK_REST);
    end
endmodule

// File: rtl/sg_regs.sv
// Register bank: control, status, current and tail pointers, plus the
// held tail write and start decision. Assumes busy is high whenever the
// walker is away from rest.
module sg_regs
    import sg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [RIDX_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              busy,
    input  logic              wk_halt,
    input  logic              wk_idle,
    input  logic              wk_adv,
    input  logic [DW-1:0]     wk_next,
    output logic              start,
    output logic              abort,
    output logic [DW-1:0]     cur_ptr,
    output logic [DW-1:0]     tail_ptr
);
    logic [DW-1:0] ctrl_q, ctrl_new, pend_val;
    logic          halted, idle, pend;
    logic          wr_ctrl, wr_tail, srst_req, run_ok, commit_now, commit_pend;

    // Decode writes, the soft-reset request and the start conditions.
    always_comb begin
        wr_ctrl     = reg_wr && (reg_addr == RI_CTRL);
        wr_tail     = reg_wr && (reg_addr == RI_TAIL);
        ctrl_new    = reg_wdata | (DW'(1) << CB_MODE) | (ctrl_q & (DW'(1) << CB_SRST));
        srst_req    = wr_ctrl && ctrl_new[CB_SRST];
        run_ok      = ctrl_q[CB_RUN] && !ctrl_q[CB_SRST];
        commit_now  = wr_tail && !busy;
        commit_pend = pend && !busy && !wr_tail;
        start       = (commit_now || commit_pend) && run_ok;
        abort       = ctrl_q[CB_SRST];
    end

    // Control register: mode bit forced, soft reset clears on read.
    always_ff @(posedge clk) begin
        if (!rst_n)                           ctrl_q <= CTRL_INIT;
        else if (srst_req)                    ctrl_q <= CTRL_INIT | (DW'(1) << CB_SRST);
        else if (wr_ctrl)                     ctrl_q <= ctrl_new;
        else if (reg_rd && reg_addr == RI_CTRL) ctrl_q[CB_SRST] <= 1'b0;
    end

    // Status flags: set by the walker, cleared by run or start.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_req) begin
            halted <= 1'b1;
            idle   <= 1'b0;
        end else begin
            if (wr_ctrl && ctrl_new[CB_RUN]) begin
                halted <= 1'b0;
                idle   <= 1'b0;
            end
            if (start)   idle   <= 1'b0;
            if (wk_halt) halted <= 1'b1;
            if (wk_idle) idle   <= 1'b1;
        end
    end

    // Current pointer: advanced by the walker, writable only at rest.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_req)                        cur_ptr <= '0;
        else if (wk_adv)                               cur_ptr <= wk_next;
        else if (reg_wr && reg_addr == RI_CUR && !busy) cur_ptr <= reg_wdata;
    end

    // Tail pointer and the tail write held while the walker is busy.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_req) begin
            tail_ptr <= '0;
            pend_val <= '0;
            pend     <= 1'b0;
        end else if (commit_now) begin
            tail_ptr <= reg_wdata;
            pend     <= 1'b0;
        end else if (wr_tail) begin
            pend_val <= reg_wdata;
            pend     <= 1'b1;
        end else if (commit_pend) begin
            tail_ptr <= pend_val;
            pend     <= 1'b0;
        end
    end

    // Combinational read mux.
    always_comb begin
        case (reg_addr)
            RI_CTRL: reg_rdata = ctrl_q;
            RI_STAT: reg_rdata = {{(DW-2){1'b0}}, idle, halted};
            RI_CUR:  reg_rdata = cur_ptr;
            RI_TAIL: reg_rdata = tail_ptr;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sg_chain_ctrl.sv
// Top of the descriptor chain sequencer: joins the register bank and the
// chain walker. Assumes an external memory with one-cycle read latency and
// an external data mover using a request / done-pulse handshake.
module sg_chain_ctrl
    import sg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [RIDX_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [DW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    output logic              xfer_req,
    output logic [DW-1:0]     xfer_addr,
    output logic [LEN_W-1:0]  xfer_len,
    output logic              xfer_sof,
    output logic              xfer_eof,
    input  logic              xfer_done,
    output logic              desc_done
);
    logic          start, abort, busy, wk_halt, wk_idle, wk_adv;
    logic [DW-1:0] cur_ptr, tail_ptr, wk_next;

    sg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .wk_halt   (wk_halt),
        .wk_idle   (wk_idle),
        .wk_adv    (wk_adv),
        .wk_next   (wk_next),
        .start     (start),
        .abort     (abort),
        .cur_ptr   (cur_ptr),
        .tail_ptr  (tail_ptr)
    );

    sg_walker u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .abort     (abort),
        .cur_ptr   (cur_ptr),
        .tail_ptr  (tail_ptr),
        .mem_rd_en (mem_rd_en),
        .mem_wr_en (mem_wr_en),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .xfer_req  (xfer_req),
        .xfer_addr (xfer_addr),
        .xfer_len  (xfer_len),
        .xfer_sof  (xfer_sof),
        .xfer_eof  (xfer_eof),
        .xfer_done (xfer_done),
        .desc_done (desc_done),
        .wk_halt   (wk_halt),
        .wk_idle   (wk_idle),
        .wk_adv    (wk_adv),
        .wk_next   (wk_next),
        .busy      (busy)
    );
endmodule

// File: rtl/sg_chain_ctrl_chk.sv
// Protocol checker for the descriptor chain sequencer, bound to the top.
// Looks only at the top-level ports.
module sg_chain_ctrl_chk
    import sg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [RIDX_W-1:0] reg_addr,
    input logic [DW-1:0]     reg_wdata,
    input logic [DW-1:0]     reg_rdata,
    input logic              mem_rd_en,
    input logic              mem_wr_en,
    input logic [DW-1:0]     mem_wdata,
    input logic              xfer_req,
    input logic [DW-1:0]     xfer_addr,
    input logic [LEN_W-1:0]  xfer_len,
    input logic              xfer_done,
    input logic              desc_done
);
    logic srst_wr;
    assign srst_wr = reg_wr && (reg_addr == RI_CTRL) && reg_wdata[CB_SRST];

    // R1: the cycle after reset, no fetch and no request are active
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!mem_rd_en && !xfer_req));

    // R2: mode bit always reads one
    p_mode_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == RI_CTRL) |-> reg_rdata[CB_MODE]);

    // R5: request held until done unless a soft reset is written
    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_done && !srst_wr) |=> xfer_req);

    // R5: request fields stable while waiting for done
    p_req_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_done && !srst_wr) |=> ($stable(xfer_addr) && $stable(xfer_len)));

    // R6: completion pulse coincides with a write-back carrying the complete bit
    p_done_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        desc_done |-> (mem_wr_en && mem_wdata[DB_CMPL]));

    // R6: completion pulse follows a done handshake
    p_done_after_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(desc_done) |-> $past(xfer_done));

    // R7: after write-back no request is active
    p_wb_then_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        desc_done |=> !xfer_req);

    // R4: read and write strobes never coincide
    p_no_rd_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));
endmodule

bind sg_chain_ctrl sg_chain_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .mem_wdata (mem_wdata),
    .xfer_req  (xfer_req),
    .xfer_addr (xfer_addr),
    .xfer_len  (xfer_len),
    .xfer_done (xfer_done),
    .desc_done (desc_done)
);

// File: tb/sg_chain_ctrl_bench.sv
// Bench: memory model, data-mover model, behavioural expectation queues
// and register-level scenarios for the descriptor chain sequencer.
module sg_chain_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_rd_en, mem_wr_en;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        xfer_req, xfer_sof, xfer_eof, desc_done;
    logic [31:0] xfer_addr;
    logic [22:0] xfer_len;
    logic        xfer_done = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;   // 50 MHz

    sg_chain_ctrl u_sg_chain_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .xfer_req(xfer_req),
        .xfer_addr(xfer_addr), .xfer_len(xfer_len), .xfer_sof(xfer_sof),
        .xfer_eof(xfer_eof), .xfer_done(xfer_done), .desc_done(desc_done)
    );

    // memory model: one-cycle read latency, word indexed
    logic [31:0] mem [0:127];
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem[mem_addr[8:2]];
        if (mem_wr_en) mem[mem_addr[8:2]] <= mem_wdata;
    end

    // data mover model: done pulse three cycles into a request
    int mv_cnt = 0;
    always @(posedge clk) begin
        if (xfer_done) begin
            xfer_done <= 1'b0;
            mv_cnt    <= 0;
        end else if (xfer_req) begin
            if (mv_cnt == 3) xfer_done <= 1'b1;
            mv_cnt <= mv_cnt + 1;
        end
    end

    // observation: requests, read addresses, completion pulses
    logic [63:0] obs_q[$];
    logic [63:0] exp_q[$];
    logic [31:0] rd_q[$];
    int          done_cnt = 0;
    logic        req_d = 1'b0;
    always @(posedge clk) begin
        req_d <= xfer_req;
        if (xfer_req && !req_d) obs_q.push_back({xfer_addr, 7'd0, xfer_sof, xfer_eof, xfer_len});
        if (mem_rd_en) rd_q.push_back(mem_addr);
        if (desc_done) done_cnt = done_cnt + 1;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
        $finish;
    end

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic put_desc(input int base, input logic [31:0] nxt, input logic [31:0] bufa,
                            input logic [31:0] ctl, input logic [31:0] sts);
        for (int i = 0; i < 8; i++) mem[base/4 + i] = 32'hDEAD_0000 + i;
        mem[base/4 + 0] = nxt;
        mem[base/4 + 2] = bufa;
        mem[base/4 + 6] = ctl;
        mem[base/4 + 7] = sts;
    endtask

    task automatic expect_xfer(input logic [31:0] a, input logic [22:0] l, input logic s, input logic e);
        exp_q.push_back({a, 7'd0, s, e, l});
    endtask

    task automatic wait_rest(output logic [31:0] st);
        st = 0;
        for (int k = 0; k < 400; k++) begin
            rd(4'd1, st);
            if (st[1:0] != 2'b00) break;
        end
    endtask

    task automatic wait_done(input int n);
        for (int k = 0; k < 2000 && done_cnt < n; k++) @(negedge clk);
    endtask

    task automatic compare_xfers(input string tag);
        check({tag, " request count"}, 64'(obs_q.size()), 64'(exp_q.size()));
        while (obs_q.size() > 0 && exp_q.size() > 0)
            check({tag, " request fields"}, obs_q.pop_front(), exp_q.pop_front());
        obs_q.delete(); exp_q.delete();
    endtask

    logic [31:0] v;
    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd(4'd0, v); check("R1 control", 64'(v), 64'h0001_0002);
        rd(4'd1, v); check("R1 status", 64'(v), 64'h1);
        rd(4'd2, v); check("R1 current", 64'(v), 64'h0);
        rd(4'd4, v); check("R1 tail", 64'(v), 64'h0);
        check("R1 no reads", 64'(rd_q.size()), 64'h0);

        // descriptor chain A -> B -> C
        put_desc(32'h000, 32'h040, 32'h1000, 32'h0800_0064, 32'h0);
        put_desc(32'h040, 32'h080, 32'h2000, 32'h03FF_FFFF, 32'h0);
        put_desc(32'h080, 32'h0C0, 32'h3000, 32'h0400_0008, 32'h0);

        // R4: tail write with run clear starts nothing
        wr(4'd2, 32'h0);
        wr(4'd4, 32'h080);
        repeat (12) @(negedge clk);
        check("R4 no fetch without run", 64'(rd_q.size()), 64'h0);
        rd(4'd4, v); check("R4 tail updated", 64'(v), 64'h080);
        rd(4'd1, v); check("R4 status unchanged", 64'(v), 64'h1);

        // R2 / R3: run write clears halted, mode bit forced, no fetch
        wr(4'd0, 32'h0000_0001);
        rd(4'd0, v); check("R2 mode bit forced", 64'(v), 64'h3);
        rd(4'd1, v); check("R3 halted cleared", 64'(v), 64'h0);
        repeat (12) @(negedge clk);
        check("R3 run alone fetches nothing", 64'(rd_q.size()), 64'h0);

        // R4..R7: walk the chain
        expect_xfer(32'h1000, 23'd100, 1'b1, 1'b0);
        expect_xfer(32'h2000, 23'h7FFFFF, 1'b0, 1'b0);
        expect_xfer(32'h3000, 23'd8, 1'b0, 1'b1);
        wr(4'd4, 32'h080);
        wait_rest(v);
        check("R7 idle after tail", 64'(v), 64'h2);
        for (int i = 0; i < 8; i++)
            check("R4 fetch order", 64'(rd_q[i]), 64'(4 * i));
        check("R4 read count", 64'(rd_q.size()), 64'd24);
        compare_xfers("R5");
        check("R6 status A", 64'(mem[32'h000/4 + 7]), 64'h8000_0064);
        check("R6 status B", 64'(mem[32'h040/4 + 7]), 64'h807F_FFFF);
        check("R6 status C", 64'(mem[32'h080/4 + 7]), 64'h8000_0008);
        check("R6 pulse count", 64'(done_cnt), 64'd3);
        rd(4'd2, v); check("R7 current follows next", 64'(v), 64'h0C0);

        // R8: pre-completed descriptor halts
        put_desc(32'h0C0, 32'h100, 32'h4000, 32'h0C00_0010, 32'h8000_0010);
        rd_q.delete();
        wr(4'd4, 32'h0C0);
        wait_rest(v);
        check("R8 halted", 64'(v), 64'h1);
        check("R8 fetched once", 64'(rd_q.size()), 64'd8);
        compare_xfers("R8");
        check("R8 no pulse", 64'(done_cnt), 64'd3);
        check("R8 status untouched", 64'(mem[32'h0C0/4 + 7]), 64'h8000_0010);
        rd(4'd2, v); check("R8 current unchanged", 64'(v), 64'h0C0);

        // R11: restart after halt from current pointer
        mem[32'h0C0/4 + 7] = 32'h0;
        wr(4'd0, 32'h1);
        rd(4'd1, v); check("R3 run clears halted", 64'(v), 64'h0);
        expect_xfer(32'h4000, 23'd16, 1'b1, 1'b1);
        wr(4'd4, 32'h0C0);
        wait_rest(v);
        check("R11 idle after restart", 64'(v), 64'h2);
        compare_xfers("R11");
        check("R11 pulse", 64'(done_cnt), 64'd4);
        rd(4'd2, v); check("R11 current", 64'(v), 64'h100);

        // R10: tail write while busy is held
        put_desc(32'h100, 32'h120, 32'h5000, 32'h0000_0020, 32'h0);
        put_desc(32'h120, 32'h140, 32'h6000, 32'h0000_0004, 32'h0);
        expect_xfer(32'h5000, 23'd32, 1'b0, 1'b0);
        expect_xfer(32'h6000, 23'd4, 1'b0, 1'b0);
        wr(4'd4, 32'h100);
        wr(4'd4, 32'h120);
        rd(4'd4, v); check("R10 tail held while busy", 64'(v), 64'h100);
        wait_done(6);
        repeat (4) @(negedge clk);
        wait_rest(v);
        check("R10 idle at end", 64'(v), 64'h2);
        compare_xfers("R10");
        check("R10 pulses", 64'(done_cnt), 64'd6);
        rd(4'd4, v); check("R10 tail committed", 64'(v), 64'h120);
        rd(4'd2, v); check("R10 current", 64'(v), 64'h140);

        // R9: soft reset and its read-clear
        wr(4'd0, 32'h4);
        rd(4'd0, v); check("R9 first read", 64'(v), 64'h0001_0006);
        rd(4'd0, v); check("R9 second read", 64'(v), 64'h0001_0002);
        rd(4'd1, v); check("R9 status halted", 64'(v), 64'h1);
        rd(4'd2, v); check("R9 current cleared", 64'(v), 64'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule